// File: doc/BRIEF.md
# Dual-Mode Microscaling Multiply-Accumulate Unit

This block multiplies two 8-bit microscaled elements and adds the scaled product into a wide signed fixed-point accumulator. Every operand arrives with three block-level fields: a mode bit, a shared power-of-two exponent and a small training bias. Each element is decoded on its own under its own block's settings, so the two operands may come from blocks in different modes.

The mode bit picks between two readings of the same byte. With the bit low (inference), the byte is a sign, a 2-bit exponent and a 5-bit fraction, which favours precision. With the bit high (training), the low six bits form a sign, a 3-bit exponent and a 2-bit fraction, which favours range. The block's bias field is added to the exponent in this mode. A zero exponent field marks a subnormal value. No code is reserved for infinity or NaN.

The product lands in the accumulator two cycles after it is presented. A clear input empties the accumulator on the edge that samples it.

Top module: `mxDualMac`

## Requirements
- R1: With the mode bit low, an element reads as sign = bit 7, exponent e = bits 6:5, fraction f = bits 4:0. For e > 0 its value is (1 + f/32) * 2^(e-1).
- R2: With the mode bit low and e = 0, the value is (f/32) * 2^0, with no implicit leading one.
- R3: With the mode bit high, an element reads as sign = bit 5, exponent e = bits 4:2, fraction f = bits 1:0, and its bias field b is unsigned. For e > 0 its value is (1 + f/4) * 2^(e-3+b). For e = 0 it is (f/4) * 2^(-2+b).
- R4: Each operand's shared exponent is a signed 8-bit two's-complement number s, and it scales that operand by 2^s.
- R5: The accumulator has 16 fraction bits. The product is multiplied by 2^16 and truncated toward zero before it is added.
- R6: A product presented with `validIn` high on one clock edge changes `accOut` on the second edge, and not on the first.
- R7: When `clearIn` is sampled high, `accOut` is zero after that edge. A product that would have landed on that edge is discarded. A product presented on the same edge as the clear is added on the following edge.
- R8: The two operands may use different modes, and each is decoded under its own mode bit and bias.
- R9: The product is negative when exactly one operand's sign is set, and it is then subtracted from the accumulator.
- R10: In training mode, bits 7:6 of the element have no effect on the result.
- R11: A product whose scaled magnitude is less than one accumulator LSB adds nothing.
- R12: With neither `validIn` two edges back nor `clearIn`, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operand pair is valid this cycle |
| clearIn | input | 1 | Zero the accumulator on this edge |
| aElem | input | 8 | Operand A element byte |
| aTrain | input | 1 | Operand A block mode (1 = training) |
| aBias | input | 4 | Operand A block training bias |
| aShared | input | 8 | Operand A signed shared block exponent |
| bElem | input | 8 | Operand B element byte |
| bTrain | input | 1 | Operand B block mode (1 = training) |
| bBias | input | 4 | Operand B block training bias |
| bShared | input | 8 | Operand B signed shared block exponent |
| accOut | output | 48 | Signed fixed-point accumulator |

## Verification
The bench builds the block with its default parameters: a 48-bit accumulator with 16 fraction bits, 8-bit shared exponents and a 4-bit training bias. With 16 fraction bits, products as small as 2^-16 and the truncation of half-LSB products can be reached with small negative shared exponents. The 48-bit width gives room to add many mixed-mode products without wrapping. A shared exponent near -100 pushes a product below the LSB, which exercises the underflow path.

// File: rtl/mxMacPkg.sv
package mxMacPkg;
  localparam int ELEM_W  = 8;
  localparam int SIG_W   = 6;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int DEXP_W  = 6;
  // decoded value = sig * 2^(sExp - EXP_OFS)
  localparam int EXP_OFS = 15;

  typedef struct packed {
    logic              sign;
    logic [SIG_W-1:0]  sig;
    logic [DEXP_W-1:0] sExp;
  } decElem_t;

  typedef struct packed {
    logic captureEn;
    logic accumEn;
    logic clearAcc;
  } macStrobe_t;
endpackage

// File: rtl/mxElemDecode.sv
module mxElemDecode
  import mxMacPkg::*;
#(
  parameter int BIAS_W = 4
) (
  input  logic [ELEM_W-1:0] elem,
  input  logic              trainMode,
  input  logic [BIAS_W-1:0] extraBias,
  output decElem_t          dec
);
  localparam int INF_ADD = EXP_OFS - 6;
  localparam int TRN_ADD = EXP_OFS - 8;

  logic [1:0] infExp;
  logic [2:0] trnExp;
  logic [DEXP_W-1:0] infEff;
  logic [DEXP_W-1:0] trnEff;

  always_comb begin
    infExp = elem[6:5];
    trnExp = elem[4:2];
    infEff = (infExp == 2'd0) ? DEXP_W'(1) : DEXP_W'(infExp);
    trnEff = (trnExp == 3'd0) ? DEXP_W'(1) : DEXP_W'(trnExp);
    if (!trainMode) begin
      dec.sign = elem[7];
      dec.sig  = {|infExp, elem[4:0]};
      dec.sExp = infEff + DEXP_W'(INF_ADD);
    end else begin
      dec.sign = elem[5];
      dec.sig  = {|trnExp, elem[1:0], 3'b000};
      dec.sExp = trnEff + DEXP_W'(extraBias) + DEXP_W'(TRN_ADD);
    end
  end

  // R1: inference exponent can only span three binades
  always_comb begin
    if (!trainMode) begin
      a_r1_inf_range: assert (dec.sExp >= DEXP_W'(INF_ADD + 1) && dec.sExp <= DEXP_W'(INF_ADD + 3));
    end
  end

  // R3: training significand carries only three meaningful bits
  always_comb begin
    if (trainMode) begin
      a_r3_trn_lowbits: assert (dec.sig[2:0] == 3'b000);
    end
  end
endmodule

// File: rtl/mxMacCtrl.sv
module mxMacCtrl
  import mxMacPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic       clearIn,
  output macStrobe_t strb
);
  logic stgValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stgValid <= 1'b0;
    else       stgValid <= validIn;
  end

  always_comb begin
    strb.captureEn = validIn;
    strb.accumEn   = stgValid;
    strb.clearAcc  = clearIn;
  end
endmodule

// File: rtl/mxMacDatapath.sv
module mxMacDatapath
  import mxMacPkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int FRAC_W = 16,
  parameter int SEXP_W = 8,
  parameter int BIAS_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  macStrobe_t               strb,
  input  logic [1:0][ELEM_W-1:0]   elems,
  input  logic [1:0]               trainModes,
  input  logic [1:0][BIAS_W-1:0]   biases,
  input  logic [1:0][SEXP_W-1:0]   shareds,
  output logic signed [ACC_W-1:0]  accQ
);
  localparam int SH_W    = SEXP_W + 4;
  localparam int SH_BASE = FRAC_W - 2 * EXP_OFS;

  decElem_t dec [2];

  for (genvar gi = 0; gi < 2; gi++) begin : g_dec
    mxElemDecode #(.BIAS_W(BIAS_W)) u_dec (
      .elem      (elems[gi]),
      .trainMode (trainModes[gi]),
      .extraBias (biases[gi]),
      .dec       (dec[gi])
    );
  end

  logic [PROD_W-1:0]      prodNext;
  logic signed [SH_W-1:0] shNext;
  logic                   signNext;

  always_comb begin
    prodNext = PROD_W'(dec[0].sig) * PROD_W'(dec[1].sig);
    signNext = dec[0].sign ^ dec[1].sign;
    shNext   = SH_W'($signed({1'b0, dec[0].sExp}))
             + SH_W'($signed({1'b0, dec[1].sExp}))
             + SH_W'($signed(shareds[0]))
             + SH_W'($signed(shareds[1]))
             + SH_W'(SH_BASE);
  end

  logic [PROD_W-1:0]      prodQ;
  logic signed [SH_W-1:0] shQ;
  logic                   signQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ <= '0;
      shQ   <= '0;
      signQ <= 1'b0;
    end else if (strb.captureEn) begin
      prodQ <= prodNext;
      shQ   <= shNext;
      signQ <= signNext;
    end
  end

  logic [ACC_W-1:0]       magWide;
  logic [ACC_W-1:0]       aligned;
  logic signed [SH_W-1:0] negSh;
  logic signed [ACC_W-1:0] term;

  always_comb begin
    magWide = ACC_W'(prodQ);
    negSh   = -shQ;
    aligned = '0;
    if (!shQ[SH_W-1]) begin
      if (shQ < SH_W'(ACC_W)) aligned = magWide << shQ;
    end else begin
      if (negSh < SH_W'(PROD_W)) aligned = magWide >> negSh;
    end
    term = signQ ? -$signed(aligned) : $signed(aligned);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              accQ <= '0;
    else if (strb.clearAcc) accQ <= '0;
    else if (strb.accumEn)  accQ <= accQ + term;
  end

  // R7: clear empties the accumulator on its edge
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAcc |=> accQ == '0);

  // R12: nothing landing means nothing changes
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accumEn && !strb.clearAcc) |=> $stable(accQ));

  // R11: a zero contribution leaves the sum untouched
  a_r11_zero_term: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accumEn && !strb.clearAcc && aligned == '0) |=> $stable(accQ));
endmodule

// File: rtl/mxDualMac.sv
module mxDualMac
  import mxMacPkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int FRAC_W = 16,
  parameter int SEXP_W = 8,
  parameter int BIAS_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    validIn,
  input  logic                    clearIn,
  input  logic [ELEM_W-1:0]       aElem,
  input  logic                    aTrain,
  input  logic [BIAS_W-1:0]       aBias,
  input  logic signed [SEXP_W-1:0] aShared,
  input  logic [ELEM_W-1:0]       bElem,
  input  logic                    bTrain,
  input  logic [BIAS_W-1:0]       bBias,
  input  logic signed [SEXP_W-1:0] bShared,
  output logic signed [ACC_W-1:0] accOut
);
  macStrobe_t strb;

  mxMacCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .clearIn (clearIn),
    .strb    (strb)
  );

  mxMacDatapath #(
    .ACC_W  (ACC_W),
    .FRAC_W (FRAC_W),
    .SEXP_W (SEXP_W),
    .BIAS_W (BIAS_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .elems      ({bElem, aElem}),
    .trainModes ({bTrain, aTrain}),
    .biases     ({bBias, aBias}),
    .shareds    ({bShared, aShared}),
    .accQ       (accOut)
  );

  // R6: a fresh product needs a valid two edges back
  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(accOut)) |-> ($past(clearIn) || $past(validIn, 2)));
endmodule

// File: tb/sim_mxDualMac.sv
module sim_mxDualMac;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0, clearIn = 1'b0;
  logic [7:0] aElem = '0, bElem = '0;
  logic aTrain = 1'b0, bTrain = 1'b0;
  logic [3:0] aBias = '0, bBias = '0;
  logic signed [7:0] aShared = '0, bShared = '0;
  logic signed [47:0] accOut;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  longint expAcc = 0;

  always #5 clk = ~clk;

  mxDualMac u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .clearIn(clearIn),
    .aElem(aElem), .aTrain(aTrain), .aBias(aBias), .aShared(aShared),
    .bElem(bElem), .bTrain(bTrain), .bBias(bBias), .bShared(bShared),
    .accOut(accOut)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act[47:0] !== exp[47:0]) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // value = sig * 2^exp, from the element layout rules
  function automatic int refSig(logic [7:0] e, logic tr);
    if (!tr) return ((e[6:5] != 0) ? 32 : 0) + int'(e[4:0]);
    return ((e[4:2] != 0) ? 4 : 0) + int'(e[1:0]);
  endfunction

  function automatic int refExp(logic [7:0] e, logic tr, logic [3:0] b);
    int ef;
    if (!tr) begin
      ef = (e[6:5] == 0) ? 1 : int'(e[6:5]);
      return ef - 6;
    end
    ef = (e[4:2] == 0) ? 1 : int'(e[4:2]);
    return ef - 5 + int'(b);
  endfunction

  function automatic longint refTerm(logic [7:0] ea, logic ta, logic [3:0] ba, int sa,
                                     logic [7:0] eb, logic tb, logic [3:0] bb, int sb);
    longint mag;
    int k;
    bit neg;
    mag = longint'(refSig(ea, ta)) * longint'(refSig(eb, tb));
    k   = refExp(ea, ta, ba) + refExp(eb, tb, bb) + sa + sb + 16;
    if (k >= 0) mag = mag <<< k;
    else if (-k >= 40) mag = 0;
    else mag = mag >>> (-k);
    neg = (ta ? ea[5] : ea[7]) ^ (tb ? eb[5] : eb[7]);
    return neg ? -mag : mag;
  endfunction

  task automatic drive(logic [7:0] ea, logic ta, logic [3:0] ba, int sa,
                       logic [7:0] eb, logic tb, logic [3:0] bb, int sb);
    aElem = ea; aTrain = ta; aBias = ba; aShared = 8'(sa);
    bElem = eb; bTrain = tb; bBias = bb; bShared = 8'(sb);
    validIn = 1'b1;
  endtask

  task automatic mac(logic [7:0] ea, logic ta, logic [3:0] ba, int sa,
                     logic [7:0] eb, logic tb, logic [3:0] bb, int sb);
    drive(ea, ta, ba, sa, eb, tb, bb, sb);
    @(negedge clk);
    validIn = 1'b0;
    @(negedge clk);
    expAcc += refTerm(ea, ta, ba, sa, eb, tb, bb, sb);
  endtask

  task automatic doClear();
    clearIn = 1'b1;
    @(negedge clk);
    clearIn = 1'b0;
    expAcc = 0;
  endtask

  task automatic testReset();
    check("R12 reset value", accOut, 0);
  endtask

  task automatic testInference();
    doClear();
    mac(8'h20, 0, 0, 0, 8'h20, 0, 0, 0);
    check("R1 1.0*1.0", accOut, 65536);
    doClear();
    mac(8'h70, 0, 0, 0, 8'h20, 0, 0, 0); // e=3 f=16 -> 1.5*4 = 6
    check("R1 6.0", accOut, 6 * 65536);
  endtask

  task automatic testSubnormal();
    doClear();
    mac(8'h10, 0, 0, 0, 8'h20, 0, 0, 0);
    check("R2 0.5 subnormal", accOut, 32768);
    doClear();
    mac(8'h01, 0, 0, 0, 8'h01, 0, 0, 0);
    check("R2 tiny subnormal", accOut, 64);
  endtask

  task automatic testTraining();
    doClear();
    mac(8'h0C, 1, 0, 0, 8'h20, 0, 0, 0);
    check("R3 trn 1.0", accOut, 65536);
    doClear();
    mac(8'h0C, 1, 4'd2, 0, 8'h20, 0, 0, 0);
    check("R3 trn bias 2", accOut, 4 * 65536);
    doClear();
    mac(8'h02, 1, 4'd1, 0, 8'h20, 0, 0, 0); // (2/4)*2^-1 = 0.25
    check("R3 trn subnormal", accOut, 16384);
  endtask

  task automatic testIgnoredBits();
    doClear();
    mac(8'hCC, 1, 4'd2, 0, 8'h20, 0, 0, 0);
    check("R10 upper bits ignored", accOut, 4 * 65536);
  endtask

  task automatic testShared();
    doClear();
    mac(8'h20, 0, 0, -3, 8'h20, 0, 0, 0);
    check("R4 shared -3", accOut, 8192);
    doClear();
    mac(8'h20, 0, 0, 2, 8'h20, 0, 0, 3);
    check("R4 shared sum 5", accOut, 32 * 65536);
  endtask

  task automatic testTruncate();
    doClear();
    mac(8'h01, 0, 0, -6, 8'h01, 0, 0, 0);
    check("R5 one lsb", accOut, 1);
    doClear();
    mac(8'h03, 0, 0, -7, 8'h01, 0, 0, 0);
    check("R5 1.5 lsb truncates", accOut, 1);
    doClear();
    mac(8'h83, 0, 0, -7, 8'h01, 0, 0, 0);
    check("R5 -1.5 lsb toward zero", accOut, -1);
  endtask

  task automatic testUnderflow();
    doClear();
    mac(8'h20, 0, 0, 0, 8'h20, 0, 0, 0);
    mac(8'h7F, 0, 0, -100, 8'h7F, 0, 0, 0);
    check("R11 below lsb adds nothing", accOut, 65536);
  endtask

  task automatic testSign();
    doClear();
    mac(8'h20, 0, 0, 0, 8'h20, 0, 0, 0);
    mac(8'hA0, 0, 0, 0, 8'h40, 0, 0, 0); // -1 * 2
    check("R9 subtract", accOut, -65536);
    mac(8'hA0, 0, 0, 0, 8'h2C, 1, 0, 0); // -1 * -1 (trn sign bit 5)
    check("R9 neg*neg", accOut, 0);
  endtask

  task automatic testLatency();
    doClear();
    drive(8'h20, 0, 0, 0, 8'h20, 0, 0, 0);
    @(negedge clk);
    validIn = 1'b0;
    check("R6 not after first edge", accOut, 0);
    @(negedge clk);
    check("R6 after second edge", accOut, 65536);
    @(negedge clk);
    check("R12 holds when idle", accOut, 65536);
    expAcc = 65536;
  endtask

  task automatic testClear();
    doClear();
    mac(8'h20, 0, 0, 0, 8'h20, 0, 0, 0);
    // product in flight when the clear edge arrives is dropped
    drive(8'h40, 0, 0, 0, 8'h20, 0, 0, 0);
    @(negedge clk);
    validIn = 1'b0;
    clearIn = 1'b1;
    @(negedge clk);
    clearIn = 1'b0;
    check("R7 clear drops in-flight", accOut, 0);
    @(negedge clk);
    check("R7 stays clear", accOut, 0);
    // product presented together with clear is kept
    mac(8'h20, 0, 0, 0, 8'h20, 0, 0, 0);
    drive(8'h40, 0, 0, 0, 8'h20, 0, 0, 0);
    clearIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    clearIn = 1'b0;
    check("R7 zero on clear edge", accOut, 0);
    @(negedge clk);
    check("R7 same-edge valid added", accOut, 2 * 65536);
    expAcc = 2 * 65536;
  endtask

  task automatic testMixed();
    logic [15:0] lfsr;
    doClear();
    mac(8'h0C, 1, 4'd3, 0, 8'h30, 0, 0, 0); // 8 * 1.5
    check("R8 trn x inf", accOut, 12 * 65536);
    lfsr = 16'hACE1;
    for (int i = 0; i < 12; i++) begin
      logic [7:0] ea, eb;
      logic ta, tb;
      logic [3:0] ba, bb;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ea = lfsr[7:0]; eb = lfsr[15:8];
      ta = lfsr[3]; tb = lfsr[9];
      ba = {1'b0, lfsr[2:0]}; bb = {1'b0, lfsr[12:10]};
      mac(ea, ta, ba, int'(lfsr[1:0]) - 2, eb, tb, bb, int'(lfsr[5:4]) - 1);
      check("R8 mixed sweep", accOut, expAcc);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInference();
    testSubnormal();
    testTraining();
    testIgnoredBits();
    testShared();
    testTruncate();
    testUnderflow();
    testSign();
    testLatency();
    testClear();
    testMixed();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule